// File: doc/BRIEF.md
# Spill-Gated Acquisition Cycle Controller

This block sequences the readout cycles of a calorimeter built from many front-end chips. A cycle opens with a one-cycle start pulse and an acquisition window. During the window a bunch-crossing tick is generated and counted. The window closes as soon as any chip reports a full event memory or the beam spill level falls. A chip memory fills after at most 16 bunch crossings with hits. After the window the controller waits, in order, for every chip to finish converting, for every chip to hand its data to its interface board, and for every interface-board link to finish sending to the aggregator. The busy output covers exactly these three drain phases.

Two operating modes exist. In test-beam mode the next cycle starts as soon as the drain is complete, provided the spill is on and all chips are ready; the bunch-crossing tick is slow. In collider mode the bunch-crossing tick is faster, the acquisition window has a fixed length, and starts are spaced by a fixed period no matter how early the drain ends. Each drain phase is guarded by a programmable timeout that aborts the cycle and raises an error flag. The mode input is taken only while the controller is idle.

Top module: `acq_cycle_ctrl`

## Requirements
- R1: The phases run acquisition, conversion, chip transfer, link transfer, in that order. Conversion advances only when every bit of `chip_conv_done_i` is high. Chip transfer advances only when every bit of `chip_xfer_done_i` is high. Link transfer ends only when every bit of `link_done_i` is high.
- R2: When any bit of `chip_full_i` is sampled high during acquisition, `acq_active_o` is low from the next cycle on.
- R3: `busy_o` is high exactly during the conversion, chip-transfer and link-transfer phases. It rises in the first cycle after acquisition ends and falls in the cycle after all link-done flags are sampled high. It is never high together with `acq_active_o`.
- R4: `start_acq_o` is a one-cycle pulse. It is issued only from idle, and only when `spill_i` is high and all bits of `chip_ready_i` are high at the preceding edge. In the pulse cycle `acq_active_o` is high.
- R5: In test-beam mode (`mode_col_i` = 0), with spill and ready held high, `start_acq_o` is high two cycles after the edge at which the link-done flags complete. This leaves one idle cycle.
- R6: In collider mode (`mode_col_i` = 1), acquisition lasts at most COL_WINDOW cycles, and consecutive starts are at least COL_PERIOD cycles apart. They are exactly COL_PERIOD apart when the drain ends early and spill and ready stay high.
- R7: `bx_en_o` pulses for one cycle every BX_DIV_TB cycles in test-beam mode, or every BX_DIV_COL cycles in collider mode, only during acquisition. The first pulse falls in cycle DIV-1, counting the start-pulse cycle as 0.
- R8: `bx_cnt_o` is zero in the start-pulse cycle. It rises by one in the cycle after each `bx_en_o` pulse, saturates at its maximum, and holds its value after acquisition.
- R9: A low `spill_i` ends acquisition at the next edge. No start is issued while `spill_i` is low.
- R10: If a drain phase lasts `tmo_limit_i`+1 cycles without its done condition, the controller goes idle. In that case `busy_o` falls and `tmo_err_o` rises. `tmo_err_o` stays high until the next start pulse clears it.
- R11: `mode_col_i` is sampled only in idle. Changing it during a cycle changes neither the tick spacing nor the window rule of that cycle.
- R12: After reset the controller is idle, with `start_acq_o`, `acq_active_o`, `bx_en_o`, `busy_o` and `tmo_err_o` low and `bx_cnt_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spill_i | input | 1 | Spill level, high while beam is delivered |
| mode_col_i | input | 1 | 1 selects collider mode, 0 test-beam mode |
| tmo_limit_i | input | TMO_W | Drain-phase timeout in cycles |
| chip_ready_i | input | N_CHIPS | Per-chip ready for a new acquisition |
| chip_full_i | input | N_CHIPS | Per-chip event memory full |
| chip_conv_done_i | input | N_CHIPS | Per-chip conversion finished |
| chip_xfer_done_i | input | N_CHIPS | Per-chip transfer to interface board finished |
| link_done_i | input | N_LINKS | Per-link transfer to aggregator finished |
| start_acq_o | output | 1 | One-cycle acquisition start pulse |
| acq_active_o | output | 1 | Acquisition window open |
| bx_en_o | output | 1 | Bunch-crossing tick |
| bx_cnt_o | output | BXCNT_W | Bunch crossings counted in this cycle |
| busy_o | output | 1 | Drain in progress |
| tmo_err_o | output | 1 | Drain phase timed out |

## Verification
The properties assume that every input changes only between clock edges and stays stable at the sampling edge. They also assume the done flags describe the current drain, so a full flag is meaningful only inside the acquisition window. The bench drives all inputs on the falling edge. It raises full and done flags only in the phases where they belong and clears them afterwards. Spill and ready changes are placed in idle or inside acquisition, where their effect is defined. A behavioural model fed the same inputs is compared with every output on every cycle.

// File: rtl/acq_cyc_pkg.sv
package acq_cyc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ACQ    = 3'd1,
      PH_CONV   = 3'd2,
      PH_CHIPXF = 3'd3,
      PH_LINKXF = 3'd4
   } phase_e;

endpackage

// File: rtl/acq_bx_gen.sv
module acq_bx_gen #(
   parameter int DIV_TB  = 8,
   parameter int DIV_COL = 2,
   parameter int CNT_W   = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             clear_i,
   input  logic             sel_col_i,
   output logic             tick_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int DMAX = (DIV_TB > DIV_COL) ? DIV_TB : DIV_COL;
   localparam int DW   = (DMAX > 1) ? $clog2(DMAX) : 1;

   logic [CNT_W-1:0] cnt_q;

   generate
      if (DMAX == 1) begin : g_every_cycle
         logic unused_sel;
         assign unused_sel = sel_col_i;
         assign tick_o     = run_i;
      end else begin : g_divider
         localparam logic [DW-1:0] LAST_TB  = DW'(DIV_TB - 1);
         localparam logic [DW-1:0] LAST_COL = DW'(DIV_COL - 1);
         logic [DW-1:0] div_q;
         logic [DW-1:0] last;
         assign last   = sel_col_i ? LAST_COL : LAST_TB;
         assign tick_o = run_i && (div_q == last);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               div_q <= '0;
            end else if (!run_i || div_q == last) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (tick_o && cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/acq_phase_timer.sv
module acq_phase_timer #(
   parameter int W = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         restart_i,
   output logic [W-1:0] cnt_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/acq_period_gate.sv
module acq_period_gate #(
   parameter int PERIOD = 200,
   parameter int WINDOW = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic in_acq_i,
   output logic period_ok_o,
   output logic window_end_o
);

   localparam int PW = $clog2(PERIOD + 1);
   localparam int WW = $clog2(WINDOW + 1);
   localparam logic [PW-1:0] P_LAST = PW'(PERIOD - 1);
   localparam logic [WW-1:0] W_LAST = WW'(WINDOW - 1);

   logic [PW-1:0] per_q;
   logic [WW-1:0] win_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q <= P_LAST;
      end else if (start_i) begin
         per_q <= '0;
      end else if (per_q != P_LAST) begin
         per_q <= per_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_q <= '0;
      end else if (!in_acq_i) begin
         win_q <= '0;
      end else if (win_q != W_LAST) begin
         win_q <= win_q + 1'b1;
      end
   end

   assign period_ok_o  = (per_q == P_LAST);
   assign window_end_o = (win_q == W_LAST);

endmodule

// File: rtl/acq_cycle_ctrl.sv
module acq_cycle_ctrl
   import acq_cyc_pkg::*;
#(
   parameter int N_CHIPS    = 4,
   parameter int N_LINKS    = 3,
   parameter int BX_DIV_TB  = 8,
   parameter int BX_DIV_COL = 2,
   parameter int COL_PERIOD = 200,
   parameter int COL_WINDOW = 20,
   parameter int BXCNT_W    = 8,
   parameter int TMO_W      = 10
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               spill_i,
   input  logic               mode_col_i,
   input  logic [TMO_W-1:0]   tmo_limit_i,
   input  logic [N_CHIPS-1:0] chip_ready_i,
   input  logic [N_CHIPS-1:0] chip_full_i,
   input  logic [N_CHIPS-1:0] chip_conv_done_i,
   input  logic [N_CHIPS-1:0] chip_xfer_done_i,
   input  logic [N_LINKS-1:0] link_done_i,
   output logic               start_acq_o,
   output logic               acq_active_o,
   output logic               bx_en_o,
   output logic [BXCNT_W-1:0] bx_cnt_o,
   output logic               busy_o,
   output logic               tmo_err_o
);

   generate
      if (N_CHIPS < 1) begin : g_bad_chips
         $error("acq_cycle_ctrl: N_CHIPS must be at least 1");
      end
      if (N_LINKS < 1) begin : g_bad_links
         $error("acq_cycle_ctrl: N_LINKS must be at least 1");
      end
      if (BX_DIV_TB < 1 || BX_DIV_COL < 1) begin : g_bad_div
         $error("acq_cycle_ctrl: bunch-crossing divisors must be at least 1");
      end
      if (COL_WINDOW < 1 || COL_PERIOD <= COL_WINDOW) begin : g_bad_period
         $error("acq_cycle_ctrl: need 1 <= COL_WINDOW < COL_PERIOD");
      end
      if (BXCNT_W < 5) begin : g_bad_bxw
         $error("acq_cycle_ctrl: BXCNT_W must hold at least 16 crossings");
      end
   endgenerate

   phase_e st_q, st_d;
   logic   mode_q, start_q, err_q;
   logic   all_ready, any_full, conv_all, xfer_all, link_all;
   logic   go_start, tmo_hit, phase_chg, expired;
   logic   period_ok, window_end;
   logic [TMO_W-1:0] tmr;

   assign all_ready = &chip_ready_i;
   assign any_full  = |chip_full_i;
   assign conv_all  = &chip_conv_done_i;
   assign xfer_all  = &chip_xfer_done_i;
   assign link_all  = &link_done_i;
   assign expired   = (tmr == tmo_limit_i);

   assign go_start = (st_q == PH_IDLE) && spill_i && all_ready &&
                     (!mode_col_i || period_ok);

   always_comb begin
      st_d    = st_q;
      tmo_hit = 1'b0;
      unique case (st_q)
         PH_IDLE: begin
            if (go_start) st_d = PH_ACQ;
         end
         PH_ACQ: begin
            if (any_full || !spill_i || (mode_q && window_end)) st_d = PH_CONV;
         end
         PH_CONV: begin
            if (conv_all) begin
               st_d = PH_CHIPXF;
            end else if (expired) begin
               st_d    = PH_IDLE;
               tmo_hit = 1'b1;
            end
         end
         PH_CHIPXF: begin
            if (xfer_all) begin
               st_d = PH_LINKXF;
            end else if (expired) begin
               st_d    = PH_IDLE;
               tmo_hit = 1'b1;
            end
         end
         PH_LINKXF: begin
            if (link_all || expired) begin
               st_d    = PH_IDLE;
               tmo_hit = !link_all;
            end
         end
         default: st_d = PH_IDLE;
      endcase
   end

   assign phase_chg = (st_d != st_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= PH_IDLE;
         mode_q  <= 1'b0;
         start_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         start_q <= go_start;
         if (st_q == PH_IDLE) mode_q <= mode_col_i;
         if (go_start) begin
            err_q <= 1'b0;
         end else if (tmo_hit) begin
            err_q <= 1'b1;
         end
      end
   end

   acq_bx_gen #(
      .DIV_TB  (BX_DIV_TB),
      .DIV_COL (BX_DIV_COL),
      .CNT_W   (BXCNT_W)
   ) u_bx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (st_q == PH_ACQ),
      .clear_i   (go_start),
      .sel_col_i (mode_q),
      .tick_o    (bx_en_o),
      .cnt_o     (bx_cnt_o)
   );

   acq_phase_timer #(
      .W (TMO_W)
   ) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (phase_chg),
      .cnt_o     (tmr)
   );

   acq_period_gate #(
      .PERIOD (COL_PERIOD),
      .WINDOW (COL_WINDOW)
   ) u_gate (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (go_start),
      .in_acq_i     (st_q == PH_ACQ),
      .period_ok_o  (period_ok),
      .window_end_o (window_end)
   );

   assign start_acq_o  = start_q;
   assign acq_active_o = (st_q == PH_ACQ);
   assign busy_o       = (st_q == PH_CONV) || (st_q == PH_CHIPXF) || (st_q == PH_LINKXF);
   assign tmo_err_o    = err_q;

endmodule

// File: rtl/acq_cycle_ctrl_chk.sv
module acq_cycle_ctrl_chk #(
   parameter int N_CHIPS = 4,
   parameter int BXCNT_W = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               spill_i,
   input logic [N_CHIPS-1:0] chip_ready_i,
   input logic [N_CHIPS-1:0] chip_full_i,
   input logic               start_acq_o,
   input logic               acq_active_o,
   input logic               bx_en_o,
   input logic [BXCNT_W-1:0] bx_cnt_o,
   input logic               busy_o,
   input logic               tmo_err_o
);

   p_full_ends_acq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acq_active_o && |chip_full_i) |=> (!acq_active_o && busy_o));

   p_busy_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_o && acq_active_o));

   p_start_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_acq_o |-> ($past(spill_i) && $past(&chip_ready_i)));

   p_start_opens_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_acq_o |-> (acq_active_o && !busy_o));

   p_start_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_acq_o |=> !start_acq_o);

   p_tick_in_acq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bx_en_o |-> acq_active_o);

   p_bx_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_acq_o |-> (bx_cnt_o == '0));

   p_bx_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bx_en_o && bx_cnt_o != '1) |=> (bx_cnt_o == $past(bx_cnt_o) + 1'b1));

   p_spill_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acq_active_o && !spill_i) |=> !acq_active_o);

   p_tmo_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tmo_err_o) |-> (!busy_o && !acq_active_o));

endmodule

bind acq_cycle_ctrl acq_cycle_ctrl_chk #(
   .N_CHIPS (N_CHIPS),
   .BXCNT_W (BXCNT_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .spill_i      (spill_i),
   .chip_ready_i (chip_ready_i),
   .chip_full_i  (chip_full_i),
   .start_acq_o  (start_acq_o),
   .acq_active_o (acq_active_o),
   .bx_en_o      (bx_en_o),
   .bx_cnt_o     (bx_cnt_o),
   .busy_o       (busy_o),
   .tmo_err_o    (tmo_err_o)
);

// File: tb/acq_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module acq_cycle_ctrl_tb_top;

   localparam int NC  = 4;
   localparam int NL  = 3;
   localparam int DT  = 8;
   localparam int DC  = 2;
   localparam int PER = 200;
   localparam int WIN = 20;
   localparam int BW  = 8;
   localparam int TW  = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          spill = 1'b0;
   logic          mode_col = 1'b0;
   logic [TW-1:0] tmo_lim = 10'd50;
   logic [NC-1:0] ready = '0;
   logic [NC-1:0] full = '0;
   logic [NC-1:0] conv = '0;
   logic [NC-1:0] xfer = '0;
   logic [NL-1:0] link = '0;
   logic          start_o, acq_o, bx_o, busy_o, err_o;
   logic [BW-1:0] bxcnt_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   acq_cycle_ctrl #(
      .N_CHIPS(NC), .N_LINKS(NL), .BX_DIV_TB(DT), .BX_DIV_COL(DC),
      .COL_PERIOD(PER), .COL_WINDOW(WIN), .BXCNT_W(BW), .TMO_W(TW)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .spill_i(spill), .mode_col_i(mode_col),
      .tmo_limit_i(tmo_lim), .chip_ready_i(ready), .chip_full_i(full),
      .chip_conv_done_i(conv), .chip_xfer_done_i(xfer), .link_done_i(link),
      .start_acq_o(start_o), .acq_active_o(acq_o), .bx_en_o(bx_o),
      .bx_cnt_o(bxcnt_o), .busy_o(busy_o), .tmo_err_o(err_o)
   );

   task automatic chk(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // behavioural reference: phase 0 idle, 1 acquire, 2 convert, 3 chip transfer, 4 link transfer
   int m_st = 0, m_start = 0, m_dcnt = 0, m_bx = 0, m_err = 0;
   int m_tmr = 0, m_win = 0, m_per = PER - 1, m_mode = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_start = 0; m_dcnt = 0; m_bx = 0; m_err = 0;
         m_tmr = 0; m_win = 0; m_per = PER - 1; m_mode = 0;
      end else begin
         int nst, div;
         bit go, tmo, tick;
         nst = m_st; go = 0; tmo = 0;
         div = m_mode ? DC : DT;
         tick = (m_st == 1) && (m_dcnt == div - 1);
         if (m_st == 0) begin
            if (spill && &ready && (!mode_col || m_per == PER - 1)) begin nst = 1; go = 1; end
         end else if (m_st == 1) begin
            if (|full || !spill || (m_mode && m_win == WIN - 1)) nst = 2;
         end else begin
            bit dn;
            dn = (m_st == 2) ? &conv : (m_st == 3) ? &xfer : &link;
            if (dn) nst = (m_st == 4) ? 0 : m_st + 1;
            else if (m_tmr == int'(tmo_lim)) begin nst = 0; tmo = 1; end
         end
         m_bx   = go ? 0 : ((tick && m_bx < 255) ? m_bx + 1 : m_bx);
         m_dcnt = (m_st != 1) ? 0 : ((m_dcnt == div - 1) ? 0 : m_dcnt + 1);
         m_win  = (m_st == 1) ? ((m_win < WIN - 1) ? m_win + 1 : m_win) : 0;
         m_tmr  = (nst != m_st) ? 0 : ((m_tmr < 1023) ? m_tmr + 1 : m_tmr);
         m_per  = go ? 0 : ((m_per < PER - 1) ? m_per + 1 : m_per);
         if (m_st == 0) m_mode = mode_col;
         m_err  = go ? 0 : (tmo ? 1 : m_err);
         m_start = go;
         m_st = nst;
      end
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         chk(start_o, m_start, "R4", "start pulse vs model");
         chk(acq_o, (m_st == 1), "R2", "acquisition window vs model");
         chk(busy_o, (m_st >= 2), "R3", "busy vs model");
         chk(bx_o, (m_st == 1) && (m_dcnt == (m_mode ? DC : DT) - 1), "R7", "bx tick vs model");
         chk(bxcnt_o, m_bx, "R8", "bx count vs model");
         chk(err_o, m_err, "R10", "timeout flag vs model");
      end
   end

   task automatic wait_start(output int c);
      c = -1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (start_o) begin c = cyc; break; end
      end
      chk(c >= 0, 1, "R4", "start pulse seen");
   endtask

   task automatic wait_tick(output int c);
      c = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bx_o) begin c = cyc; break; end
      end
      chk(c >= 0, 1, "R7", "tick seen");
   endtask

   task automatic drain_all();
      conv = '1; xfer = '1; link = '1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!busy_o) break;
      end
      conv = '0; xfer = '0; link = '0;
   endtask

   initial begin
      int cs, ct, ct2, n, nt, cs1, cs2, cs3;
      repeat (3) @(negedge clk);
      chk(busy_o, 0, "R12", "busy in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(start_o, 0, "R12", "start after reset");
      chk(acq_o, 0, "R12", "acq after reset");
      chk(bxcnt_o, 0, "R12", "bx count after reset");
      chk(err_o, 0, "R12", "error after reset");

      // test-beam cycle
      spill = 1'b1; ready = '1;
      wait_start(cs);
      chk(bxcnt_o, 0, "R8", "count zero at start");
      wait_tick(ct);
      chk(ct - cs, DT - 1, "R7", "first tick offset");
      wait_tick(ct2);
      chk(ct2 - ct, DT, "R7", "tick spacing test-beam");
      repeat (10) @(negedge clk);
      full = 4'b0100;
      @(negedge clk);
      full = '0;
      chk(acq_o, 0, "R2", "full ends acquisition");
      chk(busy_o, 1, "R3", "busy after full");
      chk(bxcnt_o, 3, "R8", "count after three ticks");
      conv = 4'b1011;
      repeat (4) @(negedge clk);
      chk(busy_o, 1, "R1", "partial convert holds");
      conv = '1;
      @(negedge clk);
      conv = '0; xfer = 4'b0111;
      repeat (5) @(negedge clk);
      chk(busy_o, 1, "R1", "partial chip transfer holds");
      xfer = '1;
      @(negedge clk);
      xfer = '0; link = 3'b011;
      repeat (5) @(negedge clk);
      chk(busy_o, 1, "R1", "partial link transfer holds");
      chk(bxcnt_o, 3, "R8", "count held during drain");
      link = '1;
      @(negedge clk);
      link = '0;
      chk(busy_o, 0, "R3", "busy falls after links done");
      chk(start_o, 0, "R5", "one idle cycle");
      @(negedge clk);
      chk(start_o, 1, "R5", "immediate restart");

      // spill drop
      repeat (3) @(negedge clk);
      spill = 1'b0;
      @(negedge clk);
      chk(acq_o, 0, "R9", "spill low ends acquisition");
      chk(busy_o, 1, "R9", "drain after spill drop");
      drain_all();
      n = 0;
      repeat (10) begin @(negedge clk); n += start_o; end
      chk(n, 0, "R9", "no start with spill low");
      ready = 4'b0111; spill = 1'b1;
      n = 0;
      repeat (10) begin @(negedge clk); n += start_o; end
      chk(n, 0, "R4", "no start with one chip not ready");
      ready = '1;
      @(negedge clk);
      chk(start_o, 1, "R4", "start once all ready");

      // timeout
      repeat (2) @(negedge clk);
      full = 4'b0001; ready = '0;
      @(negedge clk);
      full = '0;
      n = 0;
      while (busy_o && n < 200) begin n++; @(negedge clk); end
      chk(n, 51, "R10", "convert phase length before timeout");
      chk(err_o, 1, "R10", "error flag set");
      repeat (5) @(negedge clk);
      chk(err_o, 1, "R10", "error flag held in idle");
      ready = '1;
      @(negedge clk);
      chk(start_o, 1, "R10", "restart after timeout");
      chk(err_o, 0, "R10", "error cleared by start");

      // collider mode
      full = 4'b1000; ready = '0;
      @(negedge clk);
      full = '0;
      drain_all();
      mode_col = 1'b1; ready = '1;
      wait_start(cs1);
      n = 1; nt = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (i == 3) mode_col = 1'b0;
         if (!acq_o) break;
         n++;
         nt += bx_o;
      end
      chk(n, WIN, "R6", "collider window length");
      chk(nt, WIN / DC, "R11", "tick count kept after mode change");
      mode_col = 1'b1;
      drain_all();
      wait_start(cs2);
      chk(cs2 - cs1, PER, "R6", "collider start spacing");
      wait_tick(ct);
      chk(ct - cs2, DC - 1, "R7", "collider first tick");
      mode_col = 1'b0;
      @(negedge clk);
      full = 4'b0010;
      @(negedge clk);
      full = '0;
      drain_all();
      wait_start(cs3);
      chk(cs3 - cs2 < PER, 1, "R11", "test-beam mode taken in idle");
      wait_tick(ct);
      chk(ct - cs3, DT - 1, "R11", "test-beam tick after mode switch");

      spill = 1'b0;
      repeat (20) @(negedge clk);
      finish_run();
   end

endmodule